// File: doc/BRIEF.md
# Dual-Line Edge-Detecting Interrupt Aggregator

This block watches a set of peripheral event inputs and turns selected level changes into latched interrupt status. Each input has a two-bit edge-select field that enables rising-edge detection, falling-edge detection, both, or neither. A detected edge is recorded in two independent status copies, one for each of two active-low host interrupt outputs. Each output has its own mask, so two hosts can service the same sources separately.

Registers are reached through a byte-wide port with an address, a write enable, a read strobe and write data. Read data is registered. A control register selects how status is cleared: by reading a status byte (clear-on-read) or by writing ones to it (write-one-to-clear). It can also enable a one-deep hold per status bit, which keeps a second edge that arrives while the bit is still set.

Top module: `irqagg_top`

## Requirements
- R1: After reset every mask bit is 1, all status and hold state is 0, every edge-select field is 0, the control register reads 0x00 and both interrupt outputs are high.
- R2: Input i has its edge-select field in edge byte i/4 at bit offset (i mod 4)*2; the upper bit of the field enables rising edges and the lower bit enables falling edges.
- R3: With both field bits set, either edge sets status; with both bits clear, the input never sets status.
- R4: Inputs pass through a two-flop synchronizer; an input change sampled at clock edge k sets status at edge k+2, and an unmasked output falls just after that edge.
- R5: A detected edge sets the status bit of both lines in the same cycle; clearing one line's copy leaves the other line's copy unchanged.
- R6: An interrupt output is low exactly when its line has a status bit set whose mask bit is 0; a mask bit of 1 blocks that source.
- R7: With control bit 0 (clear-on-read) set, a read of a status byte returns the bits and clears them; writes to status bytes are then ignored.
- R8: With control bit 0 clear, writing a 1 to a status bit clears it and reads leave status unchanged.
- R9: With control bit 1 (hold enable) set, an edge arriving while its status bit is set is held and reappears in status after that bit is cleared, so a second clear is needed.
- R10: When a clear and a new edge on the same bit fall in the same cycle, the new edge wins and the bit stays set.
- R11: Multi-byte values are little-endian (bits 0 to 7 at the lowest address); status and mask bits at or above N, and edge bits at or above 2N, read as 0 and ignore writes.
- R12: The address map is: 0x00 control, 0x10+b status line A byte b, 0x18+b mask line A, 0x20+b status line B, 0x28+b mask line B, 0x30+b edge-select byte b; read data appears on rdata_o one cycle after the read strobe, any unmapped address reads 0x00, and rdata_o is 0x00 in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_IN | Asynchronous peripheral event inputs |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write enable for wdata_i at addr_i |
| rd_en_i | input | 1 | Read strobe for addr_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_a_n_o | output | 1 | Active-low interrupt, line A |
| irq_b_n_o | output | 1 | Active-low interrupt, line B |

## Verification
Every cycle the assertions check that a detected edge lands in both status copies even when a clear coincides with it, that a clear-on-read of a status byte empties it when no edge or held edge competes, that reads never drop bits in write-one-to-clear mode, that unmapped reads return zero, and that an interrupt output only releases when status or mask has changed. The bench runs a behavioural model in lockstep and compares both outputs and the read data on every clock. Only the scenarios can show the bit layout of the edge fields, the synchronizer latency, the held second edge needing a second read, the same-cycle collision, and the padding bits above N.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    // Address group codes (addr[7:3]); addr[2:0] selects the byte.
    localparam logic [4:0] GRP_CTRL   = 5'd0;
    localparam logic [4:0] GRP_STAT_A = 5'd2;
    localparam logic [4:0] GRP_MASK_A = 5'd3;
    localparam logic [4:0] GRP_STAT_B = 5'd4;
    localparam logic [4:0] GRP_MASK_B = 5'd5;
    localparam logic [4:0] GRP_EDGE   = 5'd6;

    localparam int LINES = 2;

    typedef struct packed {
        logic hold;   // bit 1: keep a second edge
        logic cor;    // bit 0: clear status on read
    } ctrl_t;

endpackage

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
    parameter int N_IN = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   evt_i,
    input  logic [2*N_IN-1:0] sel_i,
    output logic [N_IN-1:0]   hit_o
);

    typedef struct packed {
        logic [N_IN-1:0] s1;
        logic [N_IN-1:0] s2;
        logic [N_IN-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = evt_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_det
        assign hit_o[i] = (sel_i[2*i+1] &  sync_q.s2[i] & ~sync_q.s3[i])
                        | (sel_i[2*i]   & ~sync_q.s2[i] &  sync_q.s3[i]);
    end

endmodule

// File: rtl/irqagg_line.sv
module irqagg_line #(
    parameter int N_IN = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] hit_i,
    input  logic            cor_i,
    input  logic            hold_en_i,
    input  logic            stat_rd_i,
    input  logic            stat_wr_i,
    input  logic            mask_wr_i,
    input  logic [2:0]      byte_i,
    input  logic [7:0]      wdata_i,
    output logic [N_IN-1:0] stat_o,
    output logic [N_IN-1:0] mask_o
);

    typedef struct packed {
        logic [N_IN-1:0] stat;
        logic [N_IN-1:0] pend;
        logic [N_IN-1:0] mask;
    } line_t;

    line_t st_d, st_q;
    logic [N_IN-1:0] lane;
    logic [N_IN-1:0] wbit;
    logic [N_IN-1:0] clr;

    always_comb begin
        lane = '0;
        wbit = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (byte_i == 3'(i / 8)) begin
                lane[i] = 1'b1;
                wbit[i] = wdata_i[3'(i % 8)];
            end
        end

        clr = '0;
        if (stat_rd_i &&  cor_i) clr = lane;
        if (stat_wr_i && !cor_i) clr = clr | (lane & wbit);

        st_d = st_q;
        // A clear pulls in the held edge; a fresh edge always wins.
        st_d.stat = (clr & (st_q.pend | hit_i)) | (~clr & (st_q.stat | hit_i));
        if (hold_en_i)
            st_d.pend = (clr & st_q.pend & hit_i)
                      | (~clr & (st_q.pend | (hit_i & st_q.stat)));
        else
            st_d.pend = '0;

        if (mask_wr_i)
            st_d.mask = (st_q.mask & ~lane) | (wbit & lane);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stat <= '0;
            st_q.pend <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign mask_o = st_q.mask;

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int N_IN = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] evt_i,
    input  logic [7:0]      addr_i,
    input  logic            wr_en_i,
    input  logic            rd_en_i,
    input  logic [7:0]      wdata_i,
    output logic [7:0]      rdata_o,
    output logic            irq_a_n_o,
    output logic            irq_b_n_o
);

    localparam int ESW = 2 * N_IN;

    typedef struct packed {
        ctrl_t          ctrl;
        logic [ESW-1:0] esel;
        logic [7:0]     rdata;
    } regs_t;

    regs_t st_d, st_q;

    logic [4:0]      grp;
    logic [2:0]      bsel;
    logic [N_IN-1:0] hit_w;
    logic [N_IN-1:0] stat_w [LINES];
    logic [N_IN-1:0] mask_w [LINES];
    logic [LINES-1:0] irq_n;

    assign grp  = addr_i[7:3];
    assign bsel = addr_i[2:0];

    irqagg_edge #(.N_IN(N_IN)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_i),
        .sel_i (st_q.esel),
        .hit_o (hit_w)
    );

    for (genvar l = 0; l < LINES; l++) begin : g_line
        localparam logic [4:0] SGRP = GRP_STAT_A + 5'(2 * l);
        localparam logic [4:0] MGRP = GRP_MASK_A + 5'(2 * l);

        irqagg_line #(.N_IN(N_IN)) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_i     (hit_w),
            .cor_i     (st_q.ctrl.cor),
            .hold_en_i (st_q.ctrl.hold),
            .stat_rd_i (rd_en_i && grp == SGRP),
            .stat_wr_i (wr_en_i && grp == SGRP),
            .mask_wr_i (wr_en_i && grp == MGRP),
            .byte_i    (bsel),
            .wdata_i   (wdata_i),
            .stat_o    (stat_w[l]),
            .mask_o    (mask_w[l])
        );

        assign irq_n[l] = ~|(stat_w[l] & ~mask_w[l]);
    end

    always_comb begin
        st_d = st_q;

        if (wr_en_i && grp == GRP_CTRL && bsel == 3'd0) begin
            st_d.ctrl.cor  = wdata_i[0];
            st_d.ctrl.hold = wdata_i[1];
        end
        if (wr_en_i && grp == GRP_EDGE) begin
            for (int i = 0; i < ESW; i++)
                if (bsel == 3'(i / 8)) st_d.esel[i] = wdata_i[3'(i % 8)];
        end

        st_d.rdata = '0;
        if (rd_en_i) begin
            case (grp)
                GRP_CTRL:
                    if (bsel == 3'd0) st_d.rdata = {6'd0, st_q.ctrl.hold, st_q.ctrl.cor};
                GRP_STAT_A, GRP_MASK_A, GRP_STAT_B, GRP_MASK_B: begin
                    for (int i = 0; i < N_IN; i++) begin
                        if (bsel == 3'(i / 8)) begin
                            case (grp)
                                GRP_STAT_A: st_d.rdata[3'(i % 8)] = stat_w[0][i];
                                GRP_MASK_A: st_d.rdata[3'(i % 8)] = mask_w[0][i];
                                GRP_STAT_B: st_d.rdata[3'(i % 8)] = stat_w[1][i];
                                default:    st_d.rdata[3'(i % 8)] = mask_w[1][i];
                            endcase
                        end
                    end
                end
                GRP_EDGE:
                    for (int i = 0; i < ESW; i++)
                        if (bsel == 3'(i / 8)) st_d.rdata[3'(i % 8)] = st_q.esel[i];
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o   = st_q.rdata;
    assign irq_a_n_o = irq_n[0];
    assign irq_b_n_o = irq_n[1];

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
    parameter int N_IN = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_en_i,
    input logic            wr_en_i,
    input logic [7:0]      addr_i,
    input logic [7:0]      rdata_o,
    input logic            irq_a_n_o,
    input logic            cor,
    input logic            hold,
    input logic [N_IN-1:0] hit,
    input logic [N_IN-1:0] stat_a,
    input logic [N_IN-1:0] mask_a,
    input logic [N_IN-1:0] stat_b
);

    // R7
    cor_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cor && !hold && rd_en_i && addr_i == 8'h10 && hit == '0)
        |=> (stat_a[7:0] == 8'h00));

    // R8
    w1c_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cor && rd_en_i && !wr_en_i)
        |=> (($past(stat_a) & ~stat_a) == '0));

    // R5 R10
    edge_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0)
        |=> (((stat_a & $past(hit)) == $past(hit)) && ((stat_b & $past(hit)) == $past(hit))));

    // R12
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i[7:3] == 5'd7) |=> (rdata_o == 8'h00));

    // R6
    irq_release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_a_n_o) |-> (($past(stat_a) != stat_a) || ($past(mask_a) != mask_a)));

endmodule

bind irqagg_top irqagg_chk #(.N_IN(N_IN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en_i   (rd_en_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .rdata_o   (rdata_o),
    .irq_a_n_o (irq_a_n_o),
    .cor       (st_q.ctrl.cor),
    .hold      (st_q.ctrl.hold),
    .hit       (hit_w),
    .stat_a    (stat_w[0]),
    .mask_a    (mask_w[0]),
    .stat_b    (stat_w[1])
);

// File: tb/irqagg_top_tb.sv
module irqagg_top_tb;

    localparam int NB = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] evt = '0;
    logic [7:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          irq_a_n, irq_b_n;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irqagg_top #(.N_IN(NB)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .irq_a_n_o (irq_a_n),
        .irq_b_n_o (irq_b_n)
    );

    // ---------------- behavioural reference ----------------
    bit        m_cor, m_hold;
    bit [31:0] m_esel;
    bit [31:0] m_st [2];
    bit [31:0] m_pd [2];
    bit [31:0] m_mk [2];
    bit [31:0] m_s1, m_s2, m_s3;
    bit [7:0]  m_rd;

    function automatic bit [7:0] m_read(input bit [7:0] a);
        int g = int'(a[7:3]);
        int b = int'(a[2:0]);
        bit [7:0] r = 8'h00;
        if (g == 0 && b == 0) r = {6'd0, m_hold, m_cor};
        else if (g >= 2 && g <= 5) begin
            for (int k = 0; k < 8; k++)
                if (b*8 + k < NB)
                    r[k] = (g % 2 == 1) ? m_mk[(g-2)/2][b*8+k] : m_st[(g-2)/2][b*8+k];
        end else if (g == 6) begin
            for (int k = 0; k < 8; k++)
                if (b*8 + k < 2*NB) r[k] = m_esel[b*8+k];
        end
        return r;
    endfunction

    function automatic bit m_irq_n(input int l);
        for (int i = 0; i < NB; i++)
            if (m_st[l][i] && !m_mk[l][i]) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cor = 0; m_hold = 0; m_esel = 0; m_rd = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            for (int l = 0; l < 2; l++) begin m_st[l] = 0; m_pd[l] = 0; m_mk[l] = '1; end
        end else begin
            bit [31:0] h;
            int g, b;
            h = 0;
            g = int'(addr[7:3]);
            b = int'(addr[2:0]);
            for (int i = 0; i < NB; i++)
                h[i] = (m_esel[2*i+1] && m_s2[i] && !m_s3[i]) || (m_esel[2*i] && !m_s2[i] && m_s3[i]);
            m_rd = rd_en ? m_read(addr) : 8'h00;
            for (int l = 0; l < 2; l++) begin
                for (int i = 0; i < NB; i++) begin
                    bit c;
                    c = (g == 2 + 2*l) && (i/8 == b) &&
                        ((rd_en && m_cor) || (wr_en && !m_cor && wdata[i%8]));
                    if (c) begin
                        if (m_pd[l][i]) begin m_st[l][i] = 1; m_pd[l][i] = h[i]; end
                        else begin m_st[l][i] = h[i]; m_pd[l][i] = 0; end
                    end else if (h[i]) begin
                        if (m_st[l][i]) m_pd[l][i] = 1;
                        m_st[l][i] = 1;
                    end
                    if (!m_hold) m_pd[l][i] = 0;
                    if (wr_en && g == 3 + 2*l && i/8 == b) m_mk[l][i] = wdata[i%8];
                end
            end
            if (wr_en && g == 6)
                for (int i = 0; i < 2*NB; i++) if (i/8 == b) m_esel[i] = wdata[i%8];
            if (wr_en && addr == 8'h00) begin m_cor = wdata[0]; m_hold = wdata[1]; end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = 32'(evt);
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 line A output vs model", {7'd0, irq_a_n}, {7'd0, m_irq_n(0)});
            chk("R6 line B output vs model", {7'd0, irq_b_n}, {7'd0, m_irq_n(1)});
            chk("R12 read data vs model", rdata, m_rd);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    logic [7:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk("R1 control", v, 8'h00);
        rd(8'h18, v); chk("R1 mask A byte0", v, 8'hFF);
        rd(8'h29, v); chk("R11 mask B byte1 padding", v, 8'h03);
        rd(8'h10, v); chk("R1 status A", v, 8'h00);
        rd(8'h30, v); chk("R1 edge byte0", v, 8'h00);
        chk("R1 irq A high", {7'd0, irq_a_n}, 8'h01);

        // R3 field clear: no status
        evt[0] = 1'b1; settle();
        rd(8'h10, v); chk("R3 no edge selected", v, 8'h00);
        evt[0] = 1'b0; settle();

        // R2 rising on input 0 (byte0 bit1)
        wr(8'h30, 8'h02);
        evt[0] = 1'b1; settle();
        rd(8'h10, v); chk("R2 rising input0 line A", v, 8'h01);
        rd(8'h20, v); chk("R5 rising input0 line B", v, 8'h01);
        chk("R6 masked line A stays high", {7'd0, irq_a_n}, 8'h01);
        wr(8'h18, 8'hFE);
        chk("R6 unmasked line A low", {7'd0, irq_a_n}, 8'h00);
        chk("R6 line B still masked", {7'd0, irq_b_n}, 8'h01);
        rd(8'h10, v); chk("R8 read keeps status", v, 8'h01);
        wr(8'h10, 8'h01);
        rd(8'h10, v); chk("R8 write one clears", v, 8'h00);
        chk("R6 line A released", {7'd0, irq_a_n}, 8'h01);
        rd(8'h20, v); chk("R5 line B unaffected", v, 8'h01);

        // R2 falling only on input 0 (byte0 bit0)
        wr(8'h30, 8'h01);
        evt[0] = 1'b0; settle();
        rd(8'h10, v); chk("R2 falling input0", v, 8'h01);
        wr(8'h10, 8'h01);
        evt[0] = 1'b1; settle();
        rd(8'h10, v); chk("R2 rising ignored when falling only", v, 8'h00);

        // R3 both edges on input 5 (byte1 bits 3:2)
        wr(8'h31, 8'h0C);
        evt[5] = 1'b1; settle();
        rd(8'h10, v); chk("R3 both edges rise", v, 8'h20);
        wr(8'h10, 8'h20);
        evt[5] = 1'b0; settle();
        rd(8'h10, v); chk("R3 both edges fall", v, 8'h20);
        wr(8'h10, 8'h20);

        // R11 edge padding and byte order
        wr(8'h32, 8'hFF);
        rd(8'h32, v); chk("R11 edge bits above 2N", v, 8'h0F);
        evt[9] = 1'b1; settle();
        rd(8'h11, v); chk("R11 input9 in byte1 bit1", v, 8'h02);
        rd(8'h10, v); chk("R11 byte0 untouched", v, 8'h00);
        wr(8'h11, 8'hFF);
        rd(8'h11, v); chk("R8 byte1 cleared", v, 8'h00);

        // R7 clear-on-read
        wr(8'h00, 8'h01);
        rd(8'h00, v); chk("R7 control readback", v, 8'h01);
        evt[9] = 1'b0; settle();
        rd(8'h11, v); chk("R7 read returns bit", v, 8'h02);
        rd(8'h11, v); chk("R7 read cleared bit", v, 8'h00);
        rd(8'h21, v); chk("R5 line B kept its copy", v, 8'h02);
        evt[9] = 1'b1; settle();
        wr(8'h11, 8'hFF);
        rd(8'h11, v); chk("R7 write ignored", v, 8'h02);
        rd(8'h21, v);
        rd(8'h20, v);
        rd(8'h10, v);

        // R9 held second edge
        wr(8'h00, 8'h03);
        wr(8'h30, 8'h03);
        evt[0] = 1'b0; settle();
        evt[0] = 1'b1; settle();
        rd(8'h10, v); chk("R9 first read", v, 8'h01);
        rd(8'h10, v); chk("R9 held edge reappears", v, 8'h01);
        rd(8'h10, v); chk("R9 clean after second clear", v, 8'h00);

        // R10 clear and edge in the same cycle
        wr(8'h00, 8'h01);
        evt[0] = 1'b0; settle();
        evt[0] = 1'b1;
        repeat (2) @(negedge clk);
        rd(8'h10, v); chk("R10 old value returned", v, 8'h01);
        rd(8'h10, v); chk("R10 new edge survived clear", v, 8'h01);
        rd(8'h10, v); chk("R10 clean afterwards", v, 8'h00);

        // R4 synchronizer latency on input 1 (byte0 bits 3:2, rising)
        wr(8'h30, 8'h0B);
        wr(8'h18, 8'hFC);
        rd(8'h10, v);
        evt[1] = 1'b1;
        @(negedge clk); chk("R4 one edge later", {7'd0, irq_a_n}, 8'h01);
        @(negedge clk); chk("R4 two edges later", {7'd0, irq_a_n}, 8'h01);
        @(negedge clk); chk("R4 three edges later", {7'd0, irq_a_n}, 8'h00);

        // R12 unmapped addresses
        rd(8'h38, v); chk("R12 unmapped group", v, 8'h00);
        rd(8'h13, v); chk("R12 byte beyond status", v, 8'h00);
        rd(8'h01, v); chk("R12 control byte1", v, 8'h00);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule